// File: doc/BRIEF.md
# Accumulator ALU with Status Flags

This block is the arithmetic and logic stage of an 8-bit accumulator machine. Each cycle it takes the accumulator, the B register, a third operand byte, the current carry and auxiliary-carry bits and a 5-bit operation code. One clock later it presents the new accumulator and B values, the carry, auxiliary-carry and overflow results, and a write enable for each of the three flags. The surrounding core fetches the operand, decodes instructions and stores the status word. It commits only the flags whose enable is set.

The operations are:
- add, add with carry, and subtract with borrow;
- increment and decrement of the accumulator;
- 8x8 multiply and 8/8 divide;
- decimal adjust after a BCD addition;
- AND, OR, XOR, complement and clear;
- rotate left and right, each in a plain form and a form through carry;
- nibble swap.

Flag behaviour follows a strict rule set. Subtraction always consumes the incoming carry as a borrow. Increment, decrement, the logic group, plain rotates and swap never request a flag write.

Top module: `accalu_core`

## Requirements
- R1: Outputs are registered with one cycle of latency, and synchronous reset clears every output to zero. Opcode codes are ADD=0, ADDC=1, SUBB=2, INC=3, DEC=4, MUL=5, DIV=6, DA=7, AND=8, OR=9, XOR=10, CPL=11, CLR=12, RL=13, RLC=14, RR=15, RRC=16, SWAP=17. A flag output whose write enable is low reads 0, and B passes through unchanged except for MUL and DIV.
- R2: ADD computes A+operand, and ADDC computes A+operand+C. C is the carry out of bit 7 and AC the carry out of bit 3. OV is set when exactly one of the carries out of bits 6 and 7 occurs. All three flag enables are set. Example: 3Fh+D3h gives 12h with C=1, AC=1, OV=0.
- R3: SUBB computes A-operand-C. C is the borrow out of bit 7, AC the borrow out of bit 3, and OV is set on signed overflow. All three flag enables are set.
- R4: INC and DEC add or subtract 1 from A, wrapping modulo 256, and request no flag write.
- R5: MUL puts the low byte of A*B in A and the high byte in B. It clears C, sets OV when the product exceeds FFh, and enables C and OV only. FFh*FFh gives A=01h, B=FEh.
- R6: DIV with a nonzero B puts the quotient in A and the remainder in B, with C=0 and OV=0. It enables C and OV only.
- R7: DIV with B=0 returns A and B unchanged, with OV=1 and C=0, and enables C and OV only.
- R8: DA first adds 06h when the low nibble exceeds 9 or AC=1. It then adds 60h when the high nibble exceeds 9 or the carry is set. C is set by a carry out of either addition and never cleared, and only the C enable is set. 4Ch with AC=0 gives 52h.
- R9: AND, OR and XOR combine A with the operand, CPL inverts A and CLR zeroes A. None requests a flag write.
- R10: RL and RR rotate A by one bit within 8 bits, and SWAP exchanges its nibbles (72h gives 27h). None requests a flag write.
- R11: RLC and RRC rotate the 9-bit value formed by C and A by one bit. The bit leaving A becomes C and the old C enters the vacated end. Only the C enable is set.
- R12: Codes 18 to 31 return A and B unchanged and request no flag write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_sel | input | 5 | Operation code |
| acc_in | input | 8 | Current accumulator |
| breg_in | input | 8 | Current B register |
| opnd_in | input | 8 | Second operand byte |
| cy_in | input | 1 | Current carry flag |
| ac_in | input | 1 | Current auxiliary-carry flag |
| acc_out | output | 8 | New accumulator |
| breg_out | output | 8 | New B register |
| cy_out | output | 1 | New carry flag |
| ac_out | output | 1 | New auxiliary-carry flag |
| ov_out | output | 1 | New overflow flag |
| cy_we | output | 1 | Carry write enable |
| ac_we | output | 1 | Auxiliary-carry write enable |
| ov_we | output | 1 | Overflow write enable |

## Verification
The assertions check several properties on every cycle:
- the 9-bit sum and difference relations for ADD and SUBB;
- the product for MUL and the quotient-remainder identity for DIV;
- the zero-divisor hold;
- the flag-enable pattern of each operation class;
- the pass-through for unused codes.

The half-carry and overflow values, the two-step decimal adjust with its sticky carry, and the exact bit movement of rotates through carry are covered only by the bench. The bench reaches them with directed corner cases and random operands.

// File: rtl/accalu_pkg.sv
package accalu_pkg;

    localparam int DW  = 8;
    localparam int NW  = DW / 2;
    localparam int OPW = 5;

    typedef enum logic [OPW-1:0] {
        OP_ADD  = 5'd0,
        OP_ADDC = 5'd1,
        OP_SUBB = 5'd2,
        OP_INC  = 5'd3,
        OP_DEC  = 5'd4,
        OP_MUL  = 5'd5,
        OP_DIV  = 5'd6,
        OP_DA   = 5'd7,
        OP_AND  = 5'd8,
        OP_OR   = 5'd9,
        OP_XOR  = 5'd10,
        OP_CPL  = 5'd11,
        OP_CLR  = 5'd12,
        OP_RL   = 5'd13,
        OP_RLC  = 5'd14,
        OP_RR   = 5'd15,
        OP_RRC  = 5'd16,
        OP_SWAP = 5'd17
    } op_e;

    typedef struct packed {
        logic [DW-1:0] acc;
        logic [DW-1:0] breg;
        logic          cy;
        logic          ac;
        logic          ov;
        logic          cy_we;
        logic          ac_we;
        logic          ov_we;
    } res_t;

    localparam res_t RES_ZERO = '0;

    localparam logic [NW-1:0] BCD_MAX = NW'(9);
    localparam logic [DW:0]   DA_LO   = (DW+1)'(6);
    localparam logic [DW:0]   DA_HI   = (DW+1)'(6 << NW);

    // Restoring division: returns {remainder, quotient}.
    function automatic logic [2*DW-1:0] udiv(input logic [DW-1:0] num,
                                             input logic [DW-1:0] den);
        logic [DW:0]   rem;
        logic [DW-1:0] quo;
        rem = '0;
        quo = '0;
        for (int i = DW - 1; i >= 0; i--) begin
            rem = {rem[DW-1:0], num[i]};
            if (rem >= {1'b0, den}) begin
                rem    = rem - {1'b0, den};
                quo[i] = 1'b1;
            end
        end
        return {rem[DW-1:0], quo};
    endfunction

endpackage

// File: rtl/accalu_addsub.sv
module accalu_addsub
    import accalu_pkg::*;
(
    input  logic [OPW-1:0] op_sel,
    input  logic [DW-1:0]  acc_in,
    input  logic [DW-1:0]  opnd_in,
    input  logic           cy_in,
    input  logic           ac_in,
    output logic           hit,
    output res_t           res
);

    logic          sub_mode;
    logic          cin;
    logic [DW-1:0] opnd_eff;
    logic [DW:0]   full;
    logic          c7;
    logic          c6;
    logic          c3;
    logic [DW:0]   da_t1;
    logic [DW:0]   da_t2;
    logic          da_c1;

    always_comb begin
        sub_mode = (op_sel == OP_SUBB);
        opnd_eff = sub_mode ? ~opnd_in : opnd_in;
        cin      = sub_mode ? ~cy_in : ((op_sel == OP_ADDC) ? cy_in : 1'b0);
        full     = {1'b0, acc_in} + {1'b0, opnd_eff} + {{DW{1'b0}}, cin};
        c7       = full[DW];
        c6       = full[DW-1] ^ acc_in[DW-1] ^ opnd_eff[DW-1];
        c3       = full[NW] ^ acc_in[NW] ^ opnd_eff[NW];

        da_t1 = {1'b0, acc_in}
              + (((acc_in[NW-1:0] > BCD_MAX) || ac_in) ? DA_LO : '0);
        da_c1 = cy_in | da_t1[DW];
        da_t2 = {1'b0, da_t1[DW-1:0]}
              + (((da_t1[DW-1:NW] > BCD_MAX) || da_c1) ? DA_HI : '0);
    end

    always_comb begin
        hit = 1'b1;
        res = RES_ZERO;
        case (op_sel)
            OP_ADD, OP_ADDC: begin
                res.acc   = full[DW-1:0];
                res.cy    = c7;
                res.ac    = c3;
                res.ov    = c7 ^ c6;
                res.cy_we = 1'b1;
                res.ac_we = 1'b1;
                res.ov_we = 1'b1;
            end
            OP_SUBB: begin
                res.acc   = full[DW-1:0];
                res.cy    = ~c7;
                res.ac    = ~c3;
                res.ov    = c7 ^ c6;
                res.cy_we = 1'b1;
                res.ac_we = 1'b1;
                res.ov_we = 1'b1;
            end
            OP_INC: res.acc = acc_in + DW'(1);
            OP_DEC: res.acc = acc_in - DW'(1);
            OP_DA: begin
                res.acc   = da_t2[DW-1:0];
                res.cy    = da_c1 | da_t2[DW];
                res.cy_we = 1'b1;
            end
            default: hit = 1'b0;
        endcase
    end

endmodule

// File: rtl/accalu_muldiv.sv
module accalu_muldiv
    import accalu_pkg::*;
(
    input  logic [OPW-1:0] op_sel,
    input  logic [DW-1:0]  acc_in,
    input  logic [DW-1:0]  breg_in,
    output logic           hit,
    output res_t           res
);

    logic [2*DW-1:0] prod;
    logic [2*DW-1:0] qr;
    logic            den_zero;

    always_comb begin
        prod     = {{DW{1'b0}}, acc_in} * {{DW{1'b0}}, breg_in};
        qr       = udiv(acc_in, breg_in);
        den_zero = (breg_in == '0);
    end

    always_comb begin
        hit = 1'b1;
        res = RES_ZERO;
        case (op_sel)
            OP_MUL: begin
                res.acc   = prod[DW-1:0];
                res.breg  = prod[2*DW-1:DW];
                res.ov    = |prod[2*DW-1:DW];
                res.cy_we = 1'b1;
                res.ov_we = 1'b1;
            end
            OP_DIV: begin
                res.acc   = den_zero ? acc_in  : qr[DW-1:0];
                res.breg  = den_zero ? breg_in : qr[2*DW-1:DW];
                res.ov    = den_zero;
                res.cy_we = 1'b1;
                res.ov_we = 1'b1;
            end
            default: hit = 1'b0;
        endcase
    end

endmodule

// File: rtl/accalu_bitops.sv
module accalu_bitops
    import accalu_pkg::*;
(
    input  logic [OPW-1:0] op_sel,
    input  logic [DW-1:0]  acc_in,
    input  logic [DW-1:0]  opnd_in,
    input  logic           cy_in,
    output logic           hit,
    output res_t           res
);

    always_comb begin
        hit = 1'b1;
        res = RES_ZERO;
        case (op_sel)
            OP_AND:  res.acc = acc_in & opnd_in;
            OP_OR:   res.acc = acc_in | opnd_in;
            OP_XOR:  res.acc = acc_in ^ opnd_in;
            OP_CPL:  res.acc = ~acc_in;
            OP_CLR:  res.acc = '0;
            OP_RL:   res.acc = {acc_in[DW-2:0], acc_in[DW-1]};
            OP_RR:   res.acc = {acc_in[0], acc_in[DW-1:1]};
            OP_SWAP: res.acc = {acc_in[NW-1:0], acc_in[DW-1:NW]};
            OP_RLC: begin
                res.acc   = {acc_in[DW-2:0], cy_in};
                res.cy    = acc_in[DW-1];
                res.cy_we = 1'b1;
            end
            OP_RRC: begin
                res.acc   = {cy_in, acc_in[DW-1:1]};
                res.cy    = acc_in[0];
                res.cy_we = 1'b1;
            end
            default: hit = 1'b0;
        endcase
    end

endmodule

// File: rtl/accalu_core.sv
module accalu_core
    import accalu_pkg::*;
(
    input  logic           clk,
    input  logic           rst,
    input  logic [OPW-1:0] op_sel,
    input  logic [DW-1:0]  acc_in,
    input  logic [DW-1:0]  breg_in,
    input  logic [DW-1:0]  opnd_in,
    input  logic           cy_in,
    input  logic           ac_in,
    output logic [DW-1:0]  acc_out,
    output logic [DW-1:0]  breg_out,
    output logic           cy_out,
    output logic           ac_out,
    output logic           ov_out,
    output logic           cy_we,
    output logic           ac_we,
    output logic           ov_we
);

    logic as_hit, md_hit, bo_hit;
    res_t as_res, md_res, bo_res;
    res_t nxt_r, cur_r;

    accalu_addsub u_addsub (
        .op_sel  (op_sel),
        .acc_in  (acc_in),
        .opnd_in (opnd_in),
        .cy_in   (cy_in),
        .ac_in   (ac_in),
        .hit     (as_hit),
        .res     (as_res)
    );

    accalu_muldiv u_muldiv (
        .op_sel  (op_sel),
        .acc_in  (acc_in),
        .breg_in (breg_in),
        .hit     (md_hit),
        .res     (md_res)
    );

    accalu_bitops u_bitops (
        .op_sel  (op_sel),
        .acc_in  (acc_in),
        .opnd_in (opnd_in),
        .cy_in   (cy_in),
        .hit     (bo_hit),
        .res     (bo_res)
    );

    always_comb begin
        nxt_r      = RES_ZERO;
        nxt_r.acc  = acc_in;
        nxt_r.breg = breg_in;
        if (as_hit) begin
            nxt_r      = as_res;
            nxt_r.breg = breg_in;
        end else if (md_hit) begin
            nxt_r = md_res;
        end else if (bo_hit) begin
            nxt_r      = bo_res;
            nxt_r.breg = breg_in;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) cur_r <= RES_ZERO;
        else     cur_r <= nxt_r;
    end

    assign acc_out  = cur_r.acc;
    assign breg_out = cur_r.breg;
    assign cy_out   = cur_r.cy;
    assign ac_out   = cur_r.ac;
    assign ov_out   = cur_r.ov;
    assign cy_we    = cur_r.cy_we;
    assign ac_we    = cur_r.ac_we;
    assign ov_we    = cur_r.ov_we;

endmodule

// File: rtl/accalu_core_chk.sv
module accalu_core_chk
    import accalu_pkg::*;
(
    input logic           clk,
    input logic           rst,
    input logic [OPW-1:0] op_sel,
    input logic [DW-1:0]  acc_in,
    input logic [DW-1:0]  breg_in,
    input logic [DW-1:0]  opnd_in,
    input logic           cy_in,
    input logic [DW-1:0]  acc_out,
    input logic [DW-1:0]  breg_out,
    input logic           cy_out,
    input logic           ov_out,
    input logic           cy_we,
    input logic           ac_we,
    input logic           ov_we
);

    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> (acc_out == '0 && breg_out == '0 && !cy_out && !ov_out
                 && !cy_we && !ac_we && !ov_we));

    a_r2_add_sum: assert property (@(posedge clk) disable iff (rst)
        (op_sel == OP_ADD) |=>
        ({cy_out, acc_out} == {1'b0, $past(acc_in)} + {1'b0, $past(opnd_in)})
        && cy_we && ac_we && ov_we);

    a_r3_subb_diff: assert property (@(posedge clk) disable iff (rst)
        (op_sel == OP_SUBB) |=>
        ({cy_out, acc_out} == {1'b0, $past(acc_in)} - {1'b0, $past(opnd_in)}
                              - (DW+1)'($past(cy_in)))
        && cy_we && ac_we && ov_we);

    a_r4_incdec_no_flags: assert property (@(posedge clk) disable iff (rst)
        (op_sel == OP_INC || op_sel == OP_DEC) |=> (!cy_we && !ac_we && !ov_we));

    a_r5_mul_product: assert property (@(posedge clk) disable iff (rst)
        (op_sel == OP_MUL) |=>
        ({breg_out, acc_out} == (2*DW)'($past(acc_in)) * (2*DW)'($past(breg_in)))
        && cy_we && ov_we && !ac_we && !cy_out);

    a_r6_div_identity: assert property (@(posedge clk) disable iff (rst)
        (op_sel == OP_DIV && breg_in != '0) |=>
        ((2*DW)'(acc_out) * (2*DW)'($past(breg_in)) + (2*DW)'(breg_out)
             == (2*DW)'($past(acc_in)))
        && (breg_out < $past(breg_in)) && !ov_out && !cy_out);

    a_r7_div_zero_hold: assert property (@(posedge clk) disable iff (rst)
        (op_sel == OP_DIV && breg_in == '0) |=>
        ov_out && !cy_out && acc_out == $past(acc_in) && breg_out == '0);

    a_r9_logic_no_flags: assert property (@(posedge clk) disable iff (rst)
        (op_sel >= OP_AND && op_sel <= OP_CLR) |=>
        (!cy_we && !ac_we && !ov_we && breg_out == $past(breg_in)));

    a_r10_plain_rot_no_flags: assert property (@(posedge clk) disable iff (rst)
        (op_sel == OP_RL || op_sel == OP_RR || op_sel == OP_SWAP) |=>
        (!cy_we && !ac_we && !ov_we));

    a_r11_carry_rot_c_only: assert property (@(posedge clk) disable iff (rst)
        (op_sel == OP_RLC || op_sel == OP_RRC) |=> (cy_we && !ac_we && !ov_we));

    a_r12_unused_hold: assert property (@(posedge clk) disable iff (rst)
        (op_sel > OP_SWAP) |=>
        (acc_out == $past(acc_in) && breg_out == $past(breg_in)
         && !cy_we && !ac_we && !ov_we));

endmodule

bind accalu_core accalu_core_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .op_sel   (op_sel),
    .acc_in   (acc_in),
    .breg_in  (breg_in),
    .opnd_in  (opnd_in),
    .cy_in    (cy_in),
    .acc_out  (acc_out),
    .breg_out (breg_out),
    .cy_out   (cy_out),
    .ov_out   (ov_out),
    .cy_we    (cy_we),
    .ac_we    (ac_we),
    .ov_we    (ov_we)
);

// File: tb/accalu_core_bench.sv
module accalu_core_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [4:0] op_sel = '0;
    logic [7:0] acc_in = 8'h5A, breg_in = 8'hC3, opnd_in = 8'h77;
    logic       cy_in = 1'b1, ac_in = 1'b1;
    logic [7:0] acc_out, breg_out;
    logic       cy_out, ac_out, ov_out, cy_we, ac_we, ov_we;

    int n_checks = 0;
    int n_errors = 0;

    always #5 clk = ~clk;

    accalu_core u_accalu_core (
        .clk(clk), .rst(rst), .op_sel(op_sel), .acc_in(acc_in),
        .breg_in(breg_in), .opnd_in(opnd_in), .cy_in(cy_in), .ac_in(ac_in),
        .acc_out(acc_out), .breg_out(breg_out), .cy_out(cy_out),
        .ac_out(ac_out), .ov_out(ov_out), .cy_we(cy_we), .ac_we(ac_we),
        .ov_we(ov_we)
    );

    function automatic int sgn(input int v);
        return (v > 127) ? v - 256 : v;
    endfunction

    // Expected {acc, breg, cy, ac, ov, cy_we, ac_we, ov_we}
    function automatic logic [21:0] model(input int op, input int a, input int b,
                                          input int o, input int c, input int h);
        int ra = a, rb = b, rc = 0, rh = 0, rv = 0, wc = 0, wh = 0, wv = 0;
        int s, ci, t;
        case (op)
            0, 1: begin
                ci = (op == 1) ? c : 0;
                s  = a + o + ci;
                ra = s % 256; rc = (s > 255);
                rh = ((a % 16) + (o % 16) + ci) > 15;
                s  = sgn(a) + sgn(o) + ci;
                rv = (s > 127) || (s < -128);
                wc = 1; wh = 1; wv = 1;
            end
            2: begin
                s  = a - o - c;
                ra = (s + 256) % 256; rc = (s < 0);
                rh = ((a % 16) - (o % 16) - c) < 0;
                s  = sgn(a) - sgn(o) - c;
                rv = (s > 127) || (s < -128);
                wc = 1; wh = 1; wv = 1;
            end
            3: ra = (a + 1) % 256;
            4: ra = (a + 255) % 256;
            5: begin
                s = a * b; ra = s % 256; rb = s / 256; rv = (s > 255);
                wc = 1; wv = 1;
            end
            6: begin
                if (b == 0) rv = 1;
                else begin ra = a / b; rb = a % b; end
                wc = 1; wv = 1;
            end
            7: begin
                t = a; rc = c;
                if ((t % 16) > 9 || h != 0) t = t + 6;
                if (t > 255) rc = 1;
                t = t % 256;
                if ((t / 16) > 9 || rc != 0) t = t + 96;
                if (t > 255) rc = 1;
                ra = t % 256; wc = 1;
            end
            8:  ra = a & o;
            9:  ra = a | o;
            10: ra = a ^ o;
            11: ra = 255 - a;
            12: ra = 0;
            13: ra = ((a * 2) % 256) + (a / 128);
            14: begin ra = ((a * 2) % 256) + c; rc = a / 128; wc = 1; end
            15: ra = (a / 2) + (a % 2) * 128;
            16: begin ra = (a / 2) + c * 128; rc = a % 2; wc = 1; end
            17: ra = (a % 16) * 16 + (a / 16);
            default: ;
        endcase
        return {8'(ra), 8'(rb), 1'(rc), 1'(rh), 1'(rv), 1'(wc), 1'(wh), 1'(wv)};
    endfunction

    function automatic string tag(input int op, input int b);
        case (op)
            0, 1: return "R2";
            2: return "R3";
            3, 4: return "R4";
            5: return "R5";
            6: return (b == 0) ? "R7" : "R6";
            7: return "R8";
            8, 9, 10, 11, 12: return "R9";
            13, 15, 17: return "R10";
            14, 16: return "R11";
            default: return "R12";
        endcase
    endfunction

    task automatic check(input string req, input logic [21:0] exp_v);
        logic [21:0] got;
        got = {acc_out, breg_out, cy_out, ac_out, ov_out, cy_we, ac_we, ov_we};
        n_checks++;
        if (got !== exp_v) begin
            n_errors++;
            $display("FAIL %s: got %h expected %h", req, got, exp_v);
        end
    endtask

    task automatic run_op(input int op, input int a, input int b,
                          input int o, input int c, input int h);
        @(negedge clk);
        op_sel = 5'(op); acc_in = 8'(a); breg_in = 8'(b);
        opnd_in = 8'(o); cy_in = 1'(c); ac_in = 1'(h);
        @(negedge clk);
        check(tag(op, b), model(op, a, b, o, c, h));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        check("R1", 22'h0);              // reset clears all outputs
        rst = 1'b0;

        run_op(0, 8'h3F, 0, 8'hD3, 0, 0);     // R2 12h, C=1 AC=1 OV=0
        run_op(1, 8'h7F, 0, 8'h00, 1, 0);     // R2 carry in gives signed overflow
        run_op(2, 8'h00, 0, 8'h01, 0, 0);     // R3 borrow out
        run_op(2, 8'h80, 0, 8'h00, 1, 0);     // R3 signed overflow via borrow
        run_op(3, 8'hFF, 0, 0, 1, 1);         // R4 wrap up
        run_op(4, 8'h00, 0, 0, 0, 0);         // R4 wrap down
        run_op(5, 8'hFF, 8'hFF, 0, 1, 0);     // R5 FE01h
        run_op(5, 8'h0F, 8'h11, 0, 1, 0);     // R5 no overflow
        run_op(6, 8'hFB, 8'h12, 0, 1, 0);     // R6 13 r 17
        run_op(6, 8'h9C, 8'h00, 0, 1, 0);     // R7 zero divisor
        run_op(7, 8'h4C, 0, 0, 0, 0);         // R8 52h
        run_op(7, 8'h9A, 0, 0, 0, 0);         // R8 both nibbles, carry set
        run_op(7, 8'h12, 0, 0, 1, 1);         // R8 sticky carry and AC
        run_op(8, 8'h0F, 0, 8'hAC, 1, 1);     // R9 AND
        run_op(17, 8'h72, 0, 0, 0, 0);        // R10 swap
        run_op(13, 8'hF0, 0, 0, 1, 0);        // R10 rotate left
        run_op(16, 8'hBD, 0, 0, 0, 0);        // R11 RRC
        run_op(14, 8'h3C, 0, 0, 1, 0);        // R11 RLC
        run_op(20, 8'hA5, 8'h3C, 8'h11, 1, 1);// R12 unused code

        for (int i = 0; i < 600; i++) begin
            run_op(int'($urandom % 24), int'($urandom % 256), int'($urandom % 256),
                   int'($urandom % 256), int'($urandom % 2), int'($urandom % 2));
        end

        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check("R1", 22'h0);              // reset mid-run

        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule